// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter with a 4-1/2 digit result. It runs on the conversion clock and reads the comparator that watches the integrator. It steps the analog front end through four phases, each with its own switch enable: auto zero, signal integrate, reference integrate and integrator zero. During reference integrate it counts clocks in a five-decade BCD counter until the integrator returns through zero. It then latches the count as the reading and sets the busy, polarity, overrange and underrange flags.

The comparator output is asynchronous to the clock, so it passes through a flop synchronizer. A zero crossing is a change of the synchronized sign during reference integrate. One clock of counting is skipped at the start of reference integrate to cancel the detection delay. A run input chooses between back-to-back conversions and single conversions that are started by a rising edge.

Top module: `dslope_seq`

## Requirements
- R1: After reset the block is idle: busy_o, ovr_o, ur_o, pol_o and load_o are 0, data_o is 0, and sw_o is 4'b0001. The sw_o bits are bit0 = auto zero (also driven while idle), bit1 = signal integrate, bit2 = reference integrate, bit3 = integrator zero. A started cycle runs auto zero for AZ_LEN clocks, then signal integrate for SI_LEN clocks, then reference integrate.
- R2: busy_o is high for exactly the signal integrate and reference integrate clocks. It falls on the clock edge that follows the clock in which the crossing is detected.
- R3: If the comparator input changes during reference-integrate clock c (clock 0 is the first), the latched result is c+1. data_o holds it as BCD, with the least significant digit in data_o[3:0] and each higher digit in the next four bits.
- R4: If no crossing is detected within FS+1 reference-integrate clocks, the phase ends, ovr_o is set and data_o latches all zeros. A crossing detected in the last of those clocks takes precedence, and the result is FS-1 with no overrange.
- R5: ovr_o keeps its value through integrator zero, auto zero and signal integrate. It clears on the first clock of the next reference integrate.
- R6: When busy falls, ur_o is set if there is no overrange and the result is at most UR_LIM. It keeps its value until the first clock of the next signal integrate, where it clears.
- R7: pol_o takes the synchronized comparator level at the end of signal integrate (1 = positive). It holds that value until the next capture, including for readings near zero.
- R8: load_o is high for exactly the first clock after busy falls. data_o changes only at that point and holds its value through the following cycle.
- R9: Integrator zero lasts IZ_LEN clocks, or IZ_OR_LEN clocks when the cycle ended in overrange.
- R10: With run_i high, a new auto zero follows integrator zero directly. With run_i low at the end of integrator zero, the block idles. A rising edge of run_i while idle starts exactly one cycle. Rising edges during a cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: continuous conversion; rising edge while idle: single conversion |
| cmp_i | input | 1 | Comparator output, high while the integrator is above zero |
| sw_o | output | 4 | One-hot phase switch enables |
| busy_o | output | 1 | High during signal and reference integrate |
| pol_o | output | 1 | Input polarity, 1 = positive |
| ovr_o | output | 1 | Overrange flag |
| ur_o | output | 1 | Underrange flag |
| load_o | output | 1 | One-clock display-latch load pulse |
| data_o | output | 4*DIGITS | Latched BCD result |

## Verification
The full-scale timeout and the zero-crossing detection can fall in the same reference-integrate clock. The bench provokes this by toggling the modelled comparator two clocks and one clock before the last counting clock, and at the last counting clock. It judges the outcome from ovr_o, the busy length and data_o. The sweep also places the underrange limit on both sides of a reading, and drops and pulses run_i in the middle of a conversion to show that the cycle completes and the pulse has no effect.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_AZ,
    PH_SI,
    PH_RI,
    PH_IZ
  } phase_e;
endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dsq_bcd_cnt.sv
module dsq_bcd_cnt #(
  parameter int DIGITS  = 5,
  parameter int MSD_MAX = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   cnt_o
);
  logic [DIGITS-1:0] cy;
  assign cy[0] = inc_i;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_dec
    localparam logic [3:0] LIM = (gi == DIGITS-1) ? 4'(MSD_MAX) : 4'd9;
    logic [3:0] d_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       d_q <= '0;
      else if (clr_i)    d_q <= '0;
      else if (cy[gi])   d_q <= (d_q == LIM) ? 4'd0 : d_q + 4'd1;
    end

    if (gi < DIGITS-1) begin : g_cy
      assign cy[gi+1] = cy[gi] & (d_q == LIM);
    end

    assign cnt_o[4*gi +: 4] = d_q;

    // R3
    digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      d_q <= LIM);
  end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dsq_pkg::*;
#(
  parameter int DIGITS      = 5,
  parameter int FS          = 20000,
  parameter int AZ_LEN      = 10001,
  parameter int SI_LEN      = 10000,
  parameter int UR_LIM      = 1800,
  parameter int IZ_LEN      = 200,
  parameter int IZ_OR_LEN   = 6200,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                cmp_i,
  output logic [3:0]          sw_o,
  output logic                busy_o,
  output logic                pol_o,
  output logic                ovr_o,
  output logic                ur_o,
  output logic                load_o,
  output logic [4*DIGITS-1:0] data_o
);
  localparam int M1   = (AZ_LEN > SI_LEN) ? AZ_LEN : SI_LEN;
  localparam int M2   = (FS + 1 > IZ_OR_LEN) ? FS + 1 : IZ_OR_LEN;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXL + 2);
  localparam logic [TW-1:0] AZ_LAST = TW'(AZ_LEN - 1);
  localparam logic [TW-1:0] SI_LAST = TW'(SI_LEN - 1);
  localparam logic [TW-1:0] RI_LAST = TW'(FS);
  localparam logic [TW-1:0] IZ_LAST = TW'(IZ_LEN - 1);
  localparam logic [TW-1:0] IZ_OLAST = TW'(IZ_OR_LEN - 1);
  localparam logic [TW-1:0] UR_T    = TW'(UR_LIM + 1);

  phase_e ph_q, ph_d;
  logic [TW-1:0] tmr_q;
  logic cmp_s, cmp_d_q, run_q;
  logic busy_q, pol_q, ovr_q, ur_q, load_q;
  logic [4*DIGITS-1:0] cnt, data_q;
  logic xing, si_enter, ri_enter, ri_exit, cnt_inc;

  dsq_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  // crossing = change of the sampled sign while de-integrating
  assign xing = (ph_q == PH_RI) && (cmp_s != cmp_d_q);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (run_i && !run_q)           ph_d = PH_AZ;
      PH_AZ:   if (tmr_q == AZ_LAST)          ph_d = PH_SI;
      PH_SI:   if (tmr_q == SI_LAST)          ph_d = PH_RI;
      PH_RI:   if (xing || tmr_q == RI_LAST)  ph_d = PH_IZ;
      PH_IZ:   if (tmr_q == (ovr_q ? IZ_OLAST : IZ_LAST))
                 ph_d = run_i ? PH_AZ : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign si_enter = (ph_q == PH_AZ) && (ph_d == PH_SI);
  assign ri_enter = (ph_q == PH_SI) && (ph_d == PH_RI);
  assign ri_exit  = (ph_q == PH_RI) && (ph_d == PH_IZ);
  // first reference clock is skipped to cancel the detection delay
  assign cnt_inc  = (ph_q == PH_RI) && (tmr_q != '0) && !ri_exit;

  dsq_bcd_cnt #(.DIGITS(DIGITS), .MSD_MAX(1)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ri_enter),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      tmr_q   <= '0;
      cmp_d_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      tmr_q   <= (ph_d != ph_q || ph_q == PH_IDLE) ? '0 : tmr_q + 1'b1;
      cmp_d_q <= cmp_s;
      run_q   <= run_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pol_q  <= 1'b0;
      ovr_q  <= 1'b0;
      ur_q   <= 1'b0;
      load_q <= 1'b0;
      data_q <= '0;
    end else begin
      load_q <= ri_exit;
      if (si_enter) begin
        busy_q <= 1'b1;
        ur_q   <= 1'b0;
      end
      if (ri_enter) begin
        pol_q <= cmp_s;
        ovr_q <= 1'b0;
      end
      if (ri_exit) begin
        busy_q <= 1'b0;
        ovr_q  <= !xing;
        ur_q   <= xing && (tmr_q <= UR_T);
        data_q <= xing ? cnt : '0;
      end
    end
  end

  always_comb begin
    sw_o = 4'b0000;
    unique case (ph_q)
      PH_SI:   sw_o[1] = 1'b1;
      PH_RI:   sw_o[2] = 1'b1;
      PH_IZ:   sw_o[3] = 1'b1;
      default: sw_o[0] = 1'b1;
    endcase
  end

  assign busy_o = busy_q;
  assign pol_o  = pol_q;
  assign ovr_o  = ovr_q;
  assign ur_o   = ur_q;
  assign load_o = load_q;
  assign data_o = data_q;

  // R2
  busy_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q == (ph_q == PH_SI || ph_q == PH_RI));

  // R3
  first_ri_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RI && tmr_q == '0) |=> (cnt == '0));

  // R4
  ri_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_RI) |-> (tmr_q <= RI_LAST));

  // R5
  ovr_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ovr_q) |-> ($fell(busy_q) || (ph_q == PH_RI && $past(ph_q) == PH_SI)));

  // R6
  ur_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ur_q) |-> ($fell(busy_q) || $rose(busy_q)));

  // R6
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovr_q && ur_q));

  // R8
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> ($fell(busy_q) && ph_q == PH_IZ));

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> load_q);
endmodule

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;
  localparam int DIGITS = 5;
  localparam int FS     = 40;
  localparam int AZ     = 11;
  localparam int SI     = 10;
  localparam int URL    = 7;
  localparam int IZ     = 3;
  localparam int IZOR   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cmp = 1'b0;
  logic [3:0] sw;
  logic busy, pol, ovr, ur, load;
  logic [4*DIGITS-1:0] data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [4*DIGITS-1:0] prev_data = '0;
  bit prev_ovr = 1'b0;

  always #10 clk = ~clk;

  dslope_seq #(
    .DIGITS(DIGITS), .FS(FS), .AZ_LEN(AZ), .SI_LEN(SI), .UR_LIM(URL),
    .IZ_LEN(IZ), .IZ_OR_LEN(IZOR), .SYNC_STAGES(2)
  ) u_dslope_seq (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_i(cmp),
    .sw_o(sw), .busy_o(busy), .pol_o(pol), .ovr_o(ovr), .ur_o(ur),
    .load_o(load), .data_o(data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
    logic [4*DIGITS-1:0] r = '0;
    int x = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Entered at the negedge of the first signal-integrate clock.
  // c: reference clock in which the comparator flips (beyond FS: never).
  task automatic conv(input int c, input bit pos, input bit hold);
    int busy_cnt, k, iz, az;
    bit ovr_e, ur_e, ld1, saw_busy;
    logic [4*DIGITS-1:0] d_e;
    ovr_e = (c + 2 > FS);
    ur_e  = !ovr_e && (c + 1 <= URL);
    d_e   = ovr_e ? '0 : to_bcd(c + 1);
    chk(ur == 1'b0, "R6 ur clear at SI start", int'(ur), 0);
    chk(ovr == prev_ovr, "R5 ovr held into SI", int'(ovr), int'(prev_ovr));
    chk(data == prev_data, "R8 data held", int'(data), int'(prev_data));
    chk(sw == 4'b0010, "R1 SI switch", int'(sw), 2);
    if (hold) run = 1'b0;
    cmp = pos;
    busy_cnt = 1;
    do begin
      @(negedge clk);
      busy_cnt++;
    end while (!sw[2]);
    chk(pol == pos, "R7 polarity at RI start", int'(pol), int'(pos));
    chk(ovr == 1'b0, "R5 ovr clear at RI start", int'(ovr), 0);
    k = 0;
    forever begin
      if (k == c) cmp = ~cmp;
      if (hold && k == 0) run = 1'b1;
      if (hold && k == 1) run = 1'b0;
      @(negedge clk);
      if (!busy) break;
      busy_cnt++;
      k++;
    end
    chk(busy_cnt == SI + (ovr_e ? FS + 1 : c + 3), "R2 busy length", busy_cnt,
        SI + (ovr_e ? FS + 1 : c + 3));
    chk(ovr == ovr_e, "R4 overrange", int'(ovr), int'(ovr_e));
    chk(data == d_e, "R3 R4 result", int'(data), int'(d_e));
    chk(ur == ur_e, "R6 underrange", int'(ur), int'(ur_e));
    chk(load == 1'b1, "R8 load after busy falls", int'(load), 1);
    chk(pol == pos, "R7 polarity held", int'(pol), int'(pos));
    iz = 1;
    ld1 = 1'b1;
    forever begin
      @(negedge clk);
      if (iz == 1) ld1 = load;
      if (sw[3]) iz++;
      else break;
    end
    chk(ld1 == 1'b0, "R8 load one clock", int'(ld1), 0);
    chk(iz == (ovr_e ? IZOR : IZ), "R9 IZ length", iz, ovr_e ? IZOR : IZ);
    chk(ovr == ovr_e && ur == ur_e, "R5 R6 flags held after IZ",
        int'({ovr, ur}), int'({ovr_e, ur_e}));
    prev_data = d_e;
    prev_ovr  = ovr_e;
    if (!hold) begin
      az = 0;
      while (!busy) begin
        az++;
        @(negedge clk);
      end
      chk(az == AZ, "R10 R1 back-to-back AZ length", az, AZ);
    end else begin
      saw_busy = 1'b0;
      for (int i = 0; i < 60; i++) begin
        if (busy || sw != 4'b0001) saw_busy = 1'b1;
        @(negedge clk);
      end
      chk(!saw_busy, "R10 idle after hold, pulse ignored", int'(saw_busy), 0);
      chk(data == d_e, "R8 data held while idle", int'(data), int'(d_e));
    end
  endtask

  task automatic start_single(input bit keep);
    int n;
    run = 1'b1;
    n = 0;
    @(negedge clk);
    if (!keep) run = 1'b0;
    while (!busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == AZ, "R10 R1 AZ length after start", n, AZ);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && ovr == 1'b0 && ur == 1'b0 && load == 1'b0 && pol == 1'b0,
        "R1 reset flags", int'({busy, ovr, ur, load, pol}), 0);
    chk(data == '0, "R1 reset data", int'(data), 0);
    chk(sw == 4'b0001, "R1 reset switches", int'(sw), 1);
    start_single(1'b1);
    for (int c = 0; c <= FS + 1; c++) conv(c, c[0], 1'b0);
    conv(5, 1'b1, 1'b1);
    start_single(1'b0);
    conv(URL - 1, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule